// File: doc/BRIEF.md
# Per-Function Traffic Gating Controller

This block decides, for each virtual function, whether the datapath may hand it received packets and whether it may fetch transmit data. It keeps two enable vectors with one bit per function: one for the receive side and one for the transmit side. A function whose bits are zero stays silent until the physical function has set up its paths and written the bits to one. Transmit descriptor prefetch is handled apart from that. A function may keep filling its internal descriptor queue while its data fetch is gated, and it stops only when the queue reaches a set depth.

Resets are selective. A physical-function reset clears every enable bit. A per-function software reset or a per-function level reset clears only the two enable bits of the function it names. The block also keeps a per-function mailbox "in use" flag. No per-function reset touches that flag. It is cleared only by a direct write of zero or by a release request from the physical function.

Top module: `vf_gate_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rx_permit`, `tx_permit`, `desc_permit` and `mbx_busy` are all zero.
- R2: A write with `en_wr`=1 and `en_sel`=0 loads `en_data` into the receive vector. `rx_permit` shows the new value one cycle later. Bit i at 1 allows packet assignment to function i, and bit i at 0 blocks it.
- R3: A write with `en_wr`=1 and `en_sel`=1 loads `en_data` into the transmit vector. `tx_permit` shows the new value one cycle later. Bit i at 1 allows data fetch for function i.
- R4: A `pf_rst` pulse clears both vectors one cycle later, even if a write arrives in the same cycle. `mbx_busy` is not changed.
- R5: A `swrst_v` pulse with index `swrst_fn` clears that function's bit in both vectors. Every other bit keeps its value.
- R6: A `flr_v` pulse with index `flr_fn` clears that function's bit in both vectors, and it leaves `mbx_busy` unchanged.
- R7: When a write and a per-function reset hit the same bit in the same cycle, the bit ends at 0. The other bits take the written value.
- R8: `desc_permit[i]` is 1 exactly when, one cycle earlier, the queue level `dq_level[i*QW +: QW]` was below `DQ_DEPTH`. This holds whatever the value of `tx_permit[i]`.
- R9: `mbx_set_en` sets the flag of function `mbx_set_fn`. A direct write (`mbx_wr_en`) stores `mbx_wr_val` in the flag of function `mbx_wr_fn`.
- R10: `mbx_rel_en` clears the flag of function `mbx_rel_fn`. A clear, whether by release or by a direct write of 0, wins over a set in the same cycle.
- R11: With no write and no reset, both enable vectors and `mbx_busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| pf_rst | input | 1 | Physical-function reset pulse |
| en_wr | input | 1 | Enable-vector write strobe |
| en_sel | input | 1 | Target of the write: 0 receive, 1 transmit |
| en_data | input | NUM_FN | Full vector value to write |
| swrst_v | input | 1 | Per-function software reset pulse |
| swrst_fn | input | FIDX_W | Function index for the software reset |
| flr_v | input | 1 | Per-function level reset pulse |
| flr_fn | input | FIDX_W | Function index for the level reset |
| mbx_set_en | input | 1 | Mailbox flag set request |
| mbx_set_fn | input | FIDX_W | Function index for the set |
| mbx_wr_en | input | 1 | Direct mailbox flag write |
| mbx_wr_fn | input | FIDX_W | Function index for the direct write |
| mbx_wr_val | input | 1 | Value stored by the direct write |
| mbx_rel_en | input | 1 | Release request from the physical function |
| mbx_rel_fn | input | FIDX_W | Function index for the release |
| dq_level | input | NUM_FN*QW | Descriptor queue fill level of each function |
| rx_permit | output | NUM_FN | Receive assignment permit for each function |
| tx_permit | output | NUM_FN | Transmit data-fetch permit for each function |
| desc_permit | output | NUM_FN | Descriptor prefetch permit for each function |
| mbx_busy | output | NUM_FN | Mailbox "in use" flag for each function |

## Verification
The assertions assume that every reset and request input is a pulse sampled on the clock and that a function index is meaningful only while its valid strobe is high. The mailbox-stability property also assumes that no mailbox request coincides with the level reset it watches. The bench drives all inputs at the falling edge and raises each strobe for exactly one cycle. It keeps the mailbox strobes low whenever it checks that a level reset leaves the flags alone. Queue levels cover every code, from empty to past the depth limit, on every lane.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
  typedef enum logic {
    SEL_RX = 1'b0,
    SEL_TX = 1'b1
  } en_sel_e;
endpackage

// File: rtl/vfg_fn_decode.sv
// Turns a strobe plus a function index into a one-hot vector.
module vfg_fn_decode #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic          vld,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  hot
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hot[i] = vld && (idx == IW'(i));
  end
endmodule

// File: rtl/vfg_enable_bank.sv
// One enable vector. Precedence per bit: full clear, then the bit's own clear, then the write.
module vfg_enable_bank #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic [N-1:0] clr_vec,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_all) q[i] <= 1'b0;
      else if (clr_vec[i]) q[i] <= 1'b0;
      else if (wr_en)      q[i] <= wr_data[i];
    end
  end
endmodule

// File: rtl/vfg_mbx_flags.sv
// Mailbox "in use" flags. A clear wins over a set.
module vfg_mbx_flags #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] wr_vec,
  input  logic         wr_val,
  input  logic [N-1:0] rel_vec,
  output logic [N-1:0] q
);
  logic [N-1:0] clr_v, set_v;
  assign clr_v = rel_vec | (wr_vec & {N{~wr_val}});
  assign set_v = set_vec | (wr_vec & {N{wr_val}});

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (clr_v[i]) q[i] <= 1'b0;
      else if (set_v[i]) q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/vfg_prefetch_gate.sv
// Registered descriptor prefetch permit. It depends only on the queue level.
module vfg_prefetch_gate #(
  parameter int N     = 64,
  parameter int QW    = 5,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N*QW-1:0] level,
  output logic [N-1:0]  permit
);
  localparam logic [QW:0] DEPTH_V = DEPTH[QW:0];

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic below;
    assign below = {1'b0, level[i*QW +: QW]} < DEPTH_V;
    always_ff @(posedge clk) begin
      if (rst) permit[i] <= 1'b0;
      else     permit[i] <= below;
    end
  end
endmodule

// File: rtl/vf_gate_ctrl.sv
module vf_gate_ctrl
  import vfg_pkg::*;
#(
  parameter int NUM_FN   = 64,
  parameter int QW       = 5,
  parameter int DQ_DEPTH = 16,
  localparam int FIDX_W  = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pf_rst,
  input  logic                 en_wr,
  input  logic                 en_sel,
  input  logic [NUM_FN-1:0]    en_data,
  input  logic                 swrst_v,
  input  logic [FIDX_W-1:0]    swrst_fn,
  input  logic                 flr_v,
  input  logic [FIDX_W-1:0]    flr_fn,
  input  logic                 mbx_set_en,
  input  logic [FIDX_W-1:0]    mbx_set_fn,
  input  logic                 mbx_wr_en,
  input  logic [FIDX_W-1:0]    mbx_wr_fn,
  input  logic                 mbx_wr_val,
  input  logic                 mbx_rel_en,
  input  logic [FIDX_W-1:0]    mbx_rel_fn,
  input  logic [NUM_FN*QW-1:0] dq_level,
  output logic [NUM_FN-1:0]    rx_permit,
  output logic [NUM_FN-1:0]    tx_permit,
  output logic [NUM_FN-1:0]    desc_permit,
  output logic [NUM_FN-1:0]    mbx_busy
);
  en_sel_e sel;
  assign sel = en_sel_e'(en_sel);

  logic [NUM_FN-1:0] sw_hot, flr_hot, fn_clr;
  logic [NUM_FN-1:0] set_hot, wr_hot, rel_hot;

  vfg_fn_decode #(.N(NUM_FN), .IW(FIDX_W)) u_dec_sw  (.vld(swrst_v),    .idx(swrst_fn),   .hot(sw_hot));
  vfg_fn_decode #(.N(NUM_FN), .IW(FIDX_W)) u_dec_flr (.vld(flr_v),      .idx(flr_fn),     .hot(flr_hot));
  vfg_fn_decode #(.N(NUM_FN), .IW(FIDX_W)) u_dec_set (.vld(mbx_set_en), .idx(mbx_set_fn), .hot(set_hot));
  vfg_fn_decode #(.N(NUM_FN), .IW(FIDX_W)) u_dec_wr  (.vld(mbx_wr_en),  .idx(mbx_wr_fn),  .hot(wr_hot));
  vfg_fn_decode #(.N(NUM_FN), .IW(FIDX_W)) u_dec_rel (.vld(mbx_rel_en), .idx(mbx_rel_fn), .hot(rel_hot));

  // Both per-function resets clear the same enable bits.
  assign fn_clr = sw_hot | flr_hot;

  vfg_enable_bank #(.N(NUM_FN)) u_rx_bank (
    .clk(clk), .rst(rst), .clr_all(pf_rst), .clr_vec(fn_clr),
    .wr_en(en_wr && sel == SEL_RX), .wr_data(en_data), .q(rx_permit)
  );

  vfg_enable_bank #(.N(NUM_FN)) u_tx_bank (
    .clk(clk), .rst(rst), .clr_all(pf_rst), .clr_vec(fn_clr),
    .wr_en(en_wr && sel == SEL_TX), .wr_data(en_data), .q(tx_permit)
  );

  // The mailbox flags see no reset source except rst.
  vfg_mbx_flags #(.N(NUM_FN)) u_mbx (
    .clk(clk), .rst(rst), .set_vec(set_hot), .wr_vec(wr_hot),
    .wr_val(mbx_wr_val), .rel_vec(rel_hot), .q(mbx_busy)
  );

  vfg_prefetch_gate #(.N(NUM_FN), .QW(QW), .DEPTH(DQ_DEPTH)) u_pref (
    .clk(clk), .rst(rst), .level(dq_level), .permit(desc_permit)
  );
endmodule

// File: rtl/vf_gate_ctrl_chk.sv
module vf_gate_ctrl_chk #(
  parameter int NUM_FN   = 64,
  parameter int QW       = 5,
  parameter int DQ_DEPTH = 16,
  localparam int FIDX_W  = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pf_rst,
  input logic                 en_wr,
  input logic                 en_sel,
  input logic [NUM_FN-1:0]    en_data,
  input logic                 swrst_v,
  input logic [FIDX_W-1:0]    swrst_fn,
  input logic                 flr_v,
  input logic [FIDX_W-1:0]    flr_fn,
  input logic                 mbx_set_en,
  input logic [FIDX_W-1:0]    mbx_set_fn,
  input logic                 mbx_wr_en,
  input logic [FIDX_W-1:0]    mbx_wr_fn,
  input logic                 mbx_wr_val,
  input logic                 mbx_rel_en,
  input logic [FIDX_W-1:0]    mbx_rel_fn,
  input logic [NUM_FN*QW-1:0] dq_level,
  input logic [NUM_FN-1:0]    rx_permit,
  input logic [NUM_FN-1:0]    tx_permit,
  input logic [NUM_FN-1:0]    desc_permit,
  input logic [NUM_FN-1:0]    mbx_busy
);
  localparam logic [QW:0] DEPTH_V = DQ_DEPTH[QW:0];

  // R4
  pf_rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    pf_rst |=> (rx_permit == '0) && (tx_permit == '0));

  // R5
  swrst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    swrst_v |=> !rx_permit[$past(swrst_fn)] && !tx_permit[$past(swrst_fn)]);

  // R6
  flr_keeps_mbx_chk: assert property (@(posedge clk) disable iff (rst)
    (flr_v && !mbx_set_en && !mbx_wr_en && !mbx_rel_en) |=> $stable(mbx_busy));

  // R10
  release_clears_chk: assert property (@(posedge clk) disable iff (rst)
    mbx_rel_en |=> !mbx_busy[$past(mbx_rel_fn)]);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_wr && !pf_rst && !swrst_v && !flr_v) |=> $stable(rx_permit) && $stable(tx_permit));

  for (genvar i = 0; i < NUM_FN; i++) begin : g_lane
    // R8
    prefetch_level_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> desc_permit[i] == ({1'b0, $past(dq_level[i*QW +: QW])} < DEPTH_V));
  end
endmodule

bind vf_gate_ctrl vf_gate_ctrl_chk #(
  .NUM_FN(NUM_FN), .QW(QW), .DQ_DEPTH(DQ_DEPTH)
) u_chk (.*);

// File: tb/vf_gate_ctrl_tb.sv
`timescale 1ns/1ps
module vf_gate_ctrl_tb;
  localparam int N = 8, QW = 3, DEPTH = 5, IW = 3;

  logic clk = 1'b0;
  logic rst, pf_rst, en_wr, en_sel, swrst_v, flr_v;
  logic mbx_set_en, mbx_wr_en, mbx_wr_val, mbx_rel_en;
  logic [N-1:0] en_data;
  logic [IW-1:0] swrst_fn, flr_fn, mbx_set_fn, mbx_wr_fn, mbx_rel_fn;
  logic [N*QW-1:0] dq_level;
  logic [N-1:0] rx_permit, tx_permit, desc_permit, mbx_busy;

  vf_gate_ctrl #(.NUM_FN(N), .QW(QW), .DQ_DEPTH(DEPTH)) u_dut (.*);

  always #2.5 clk = ~clk;

  int vecs = 0, miss = 0;
  bit done = 1'b0;
  logic [N-1:0] m_rx = '0, m_tx = '0, m_mbx = '0, m_desc = '0;

  function automatic logic [N-1:0] hot(input logic v, input logic [IW-1:0] f);
    return v ? (N'(1) << f) : '0;
  endfunction

  task automatic check(input string tag, input string fld, input logic [N-1:0] act, input logic [N-1:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  task automatic clear_strobes();
    pf_rst = 0; en_wr = 0; swrst_v = 0; flr_v = 0;
    mbx_set_en = 0; mbx_wr_en = 0; mbx_rel_en = 0;
  endtask

  // Model of the requirements, then one clock, then a check at the falling edge.
  task automatic step(input string tag);
    logic [N-1:0] fclr, mclr, mset, wrv;
    fclr = hot(swrst_v, swrst_fn) | hot(flr_v, flr_fn);
    wrv  = hot(mbx_wr_en, mbx_wr_fn);
    mclr = hot(mbx_rel_en, mbx_rel_fn) | (wrv & {N{~mbx_wr_val}});
    mset = hot(mbx_set_en, mbx_set_fn) | (wrv & {N{mbx_wr_val}});
    if (rst) begin
      m_rx = '0; m_tx = '0; m_mbx = '0; m_desc = '0;
    end else begin
      if (pf_rst) begin m_rx = '0; m_tx = '0; end
      else begin
        if (en_wr && !en_sel) m_rx = en_data;
        if (en_wr &&  en_sel) m_tx = en_data;
        m_rx &= ~fclr; m_tx &= ~fclr;
      end
      m_mbx = (m_mbx | mset) & ~mclr;
      for (int i = 0; i < N; i++) m_desc[i] = (int'(dq_level[i*QW +: QW]) < DEPTH);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rx_permit", rx_permit, m_rx);
    check(tag, "tx_permit", tx_permit, m_tx);
    check(tag, "desc_permit", desc_permit, m_desc);
    check(tag, "mbx_busy", mbx_busy, m_mbx);
    clear_strobes();
  endtask

  task automatic set_levels(input int base);
    for (int i = 0; i < N; i++) dq_level[i*QW +: QW] = QW'((base + i) % 8);
  endtask

  task automatic wr_en_vec(input logic s, input logic [N-1:0] d, input string tag);
    en_wr = 1; en_sel = s; en_data = d; step(tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    clear_strobes();
    rst = 1; en_sel = 0; en_data = '0; mbx_wr_val = 0;
    swrst_fn = 0; flr_fn = 0; mbx_set_fn = 0; mbx_wr_fn = 0; mbx_rel_fn = 0;
    dq_level = '1;
    @(negedge clk);
    step("R1 in reset");
    step("R1 in reset");
    rst = 0;
    step("R1 after reset");

    // R2 / R3: one-hot and mixed vectors on each register
    for (int i = 0; i < N; i++) wr_en_vec(1'b0, N'(1) << i, "R2 rx one-hot");
    for (int k = 0; k < 16; k++) wr_en_vec(1'b0, N'(k * 29 + 3), "R2 rx pattern");
    for (int i = 0; i < N; i++) wr_en_vec(1'b1, N'(1) << i, "R3 tx one-hot");
    for (int k = 0; k < 16; k++) wr_en_vec(1'b1, N'(k * 53 + 7), "R3 tx pattern");

    // R11
    for (int k = 0; k < 3; k++) step("R11 hold");

    // R5: software reset per function
    for (int f = 0; f < N; f++) begin
      wr_en_vec(1'b0, '1, "R5 prep rx");
      wr_en_vec(1'b1, '1, "R5 prep tx");
      swrst_v = 1; swrst_fn = IW'(f); step("R5 swrst one function");
    end

    // R9: set every mailbox flag
    for (int f = 0; f < N; f++) begin
      mbx_set_en = 1; mbx_set_fn = IW'(f); step("R9 set flag");
    end

    // R6: level reset clears enables, keeps flags
    for (int f = 0; f < N; f++) begin
      wr_en_vec(1'b0, '1, "R6 prep rx");
      wr_en_vec(1'b1, '1, "R6 prep tx");
      flr_v = 1; flr_fn = IW'(f); step("R6 flr keeps mailbox");
    end

    // R7: reset beats write on the same bit
    for (int f = 0; f < N; f++) begin
      en_wr = 1; en_sel = 0; en_data = '1; flr_v = 1; flr_fn = IW'(f);
      step("R7 flr vs rx write");
      en_wr = 1; en_sel = 1; en_data = '1; swrst_v = 1; swrst_fn = IW'(N - 1 - f);
      step("R7 swrst vs tx write");
    end

    // R4: PF reset with and without a write in the same cycle
    wr_en_vec(1'b0, 8'hA5, "R4 prep");
    wr_en_vec(1'b1, 8'h5A, "R4 prep");
    pf_rst = 1; step("R4 pf reset");
    wr_en_vec(1'b0, 8'hFF, "R4 prep");
    pf_rst = 1; en_wr = 1; en_sel = 1; en_data = 8'hFF; step("R4 pf reset beats write");

    // R8: every level code on every lane, tx gated and open
    for (int t = 0; t < 2; t++) begin
      wr_en_vec(1'b1, t ? 8'hFF : 8'h00, "R8 tx setting");
      for (int b = 0; b < 8; b++) begin
        set_levels(b); step("R8 prefetch vs level");
      end
    end

    // R9 / R10: direct writes, release, and clear-over-set
    for (int f = 0; f < N; f++) begin
      mbx_wr_en = 1; mbx_wr_fn = IW'(f); mbx_wr_val = 0; step("R9 direct write 0");
      mbx_wr_en = 1; mbx_wr_fn = IW'(f); mbx_wr_val = 1; step("R9 direct write 1");
      mbx_rel_en = 1; mbx_rel_fn = IW'(f); step("R10 release");
      mbx_set_en = 1; mbx_set_fn = IW'(f); mbx_rel_en = 1; mbx_rel_fn = IW'(f);
      step("R10 release beats set");
      mbx_set_en = 1; mbx_set_fn = IW'(f); mbx_wr_en = 1; mbx_wr_fn = IW'(f); mbx_wr_val = 0;
      step("R10 write 0 beats set");
      mbx_set_en = 1; mbx_set_fn = IW'(f); step("R9 set again");
    end
    step("R11 hold flags");

    done = 1'b1;
    finish_run();
  end
endmodule